// File: doc/BRIEF.md
# Headset Jack Detection Debouncer

This block turns two raw, already digitized jack comparator outputs into clean state. One input says whether a plug is in the jack. The other is the microphone sense line, which a plug with a microphone holds high and which a pressed headset button pulls low. Both inputs are resynchronized and then filtered. A new level is accepted only after a run of agreeing samples on a slow tick. The result is a 2-bit jack status code and a debounced button-press flag.

All timing comes from a 1 MHz reference enable. A prescaler turns that enable into a 1 ms base tick, and a binary divider chain turns the base tick into 2, 4, 8, 16, 32 and 64 ms ticks. A single 6-bit configuration register holds the settings, and it is written with a one-cycle strobe. It sets the detection enable, a 3-bit plug debounce code and a 2-bit button debounce code. Each code selects a sample tick, and a window is always eight ticks long. The register reads back together with the status code.

Top module: `headset_debounce_top`

## Requirements
- R1: After reset the configuration is all zero, the status is 00, the button flag is 0 and cfgRdData reads 0x00.
- R2: While the enable bit (cfgWdata[0]) is 0, the status is 00 and the button flag is 0 whatever the inputs do. Disabling also clears all filter state.
- R3: The status is 01 when a plug without microphone is accepted and 11 when a plug with microphone is accepted. The value 10 is never output.
- R4: A plug-input level is accepted after 8 consecutive agreeing samples of the tick picked by the plug code in cfgWdata[3:1]. Code n (0..5) uses a tick of 2^(n+1) ms, so windows run from 16 ms to 512 ms.
- R5: Plug codes 6 and 7 behave exactly like code 5 (64 ms tick), and they read back as written.
- R6: A sample that disagrees with the pending level restarts the count, so a pulse shorter than the window never changes the status.
- R7: Button code 0 (cfgWdata[5:4]) bypasses filtering: the flag follows a low microphone line within 4 clock cycles.
- R8: Button code n (1..3) accepts a press or a release after 8 agreeing samples of a 2^(n-1) ms tick.
- R9: The microphone line is sampled only while the plug is accepted as present. When the plug is accepted as removed, the status goes to 00 and the button flag goes to 0 at once, and the microphone and button filters restart.
- R10: Writing a different plug code restarts the plug and microphone sample counts, and writing a different button code restarts the button count. No partial window carries over.
- R11: cfgRdData reads {status[1:0], button code[1:0], plug code[2:0], enable}, with the enable in bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| refTick | input | 1 | One-cycle 1 MHz reference enable |
| headsetRaw | input | 1 | Raw plug-present comparator output |
| micRaw | input | 1 | Raw microphone sense line (high: mic present, low: button pressed) |
| cfgWe | input | 1 | Configuration write strobe |
| cfgWdata | input | 6 | Configuration write data: {button code, plug code, enable} |
| cfgRdData | output | 8 | Configuration and status readback |
| status | output | 2 | Jack status: 00 none, 01 plug without mic, 11 plug with mic |
| buttonPressed | output | 1 | Debounced button-press flag |

## Verification
The plug input is held at steady levels and sampled just short of and just past the eight-tick window. This tells a correct tick choice apart from a neighbouring code, and the reserved codes apart from shorter settings. A short low pulse on a present plug separates restart-on-disagreement from a counter that only accumulates. A code change in mid-window separates a restarted count from a leftover one. The microphone line is held high while the plug is absent, and then driven through presses with each button code, including the unfiltered code 0. This separates gating by plug state and correct button timing from a free-running microphone filter.

// File: rtl/hsdet_pkg.sv
package hsdet_pkg;

  // Highest divider exponent: base tick times 2^6 = 64 ms.
  localparam int MAX_TICK_EXP = 6;
  localparam int PLUG_CODE_W  = 3;
  localparam int BTN_CODE_W   = 2;
  localparam int CFG_W        = 1 + PLUG_CODE_W + BTN_CODE_W;
  localparam logic [PLUG_CODE_W-1:0] PLUG_CODE_MAX = 3'd5;

  typedef enum logic [1:0] {
    JACK_EMPTY   = 2'b00,
    JACK_NO_MIC  = 2'b01,
    JACK_UNUSED  = 2'b10,
    JACK_WITH_MIC = 2'b11
  } jackStatus_e;

  typedef struct packed {
    logic [BTN_CODE_W-1:0]  btnCode;
    logic [PLUG_CODE_W-1:0] plugCode;
    logic                   enable;
  } detCfg_t;

  typedef struct packed {
    logic plugTick;     // sample strobe for plug and mic filters
    logic btnTick;      // sample strobe for button filter
    logic btnBypass;    // button filter follows its input
    logic plugRestart;  // plug code changed
    logic btnRestart;   // button code changed
    logic clearAll;     // detection disabled
  } ctrlStrobes_t;

endpackage

// File: rtl/hsdet_filter.sv
module hsdet_filter #(
  parameter int SAMPLES = 8
) (
  input  logic clk,
  input  logic rstN,
  input  logic clear,
  input  logic restart,
  input  logic bypass,
  input  logic sampleTick,
  input  logic din,
  output logic stable
);
  localparam int CNT_W = (SAMPLES > 1) ? $clog2(SAMPLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SAMPLES - 1);

  logic [CNT_W-1:0] agreeCnt;

  always_ff @(posedge clk) begin
    if (!rstN || clear) begin
      stable   <= 1'b0;
      agreeCnt <= '0;
    end else if (bypass) begin
      stable   <= din;
      agreeCnt <= '0;
    end else if (restart) begin
      agreeCnt <= '0;
    end else if (sampleTick) begin
      if (din == stable) begin
        agreeCnt <= '0;
      end else if (agreeCnt == LAST) begin
        stable   <= din;
        agreeCnt <= '0;
      end else begin
        agreeCnt <= agreeCnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/hsdet_ctrl.sv
module hsdet_ctrl
  import hsdet_pkg::*;
#(
  parameter int PRESCALE = 1000
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             refTick,
  input  logic             cfgWe,
  input  logic [CFG_W-1:0] cfgWdata,
  output detCfg_t          cfg,
  output ctrlStrobes_t     strobes
);
  localparam int PRE_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRESCALE - 1);

  detCfg_t                 cfgNext;
  logic [PRE_W-1:0]        preCnt;
  logic                    baseTick;
  logic [MAX_TICK_EXP-1:0] divCnt;
  logic [MAX_TICK_EXP:0]   tickVec;
  logic [PLUG_CODE_W-1:0]  plugSel;
  logic [PLUG_CODE_W-1:0]  plugIdx;
  logic                    btnTickSel;

  assign cfgNext = detCfg_t'(cfgWdata);

  // configuration register
  always_ff @(posedge clk) begin
    if (!rstN)      cfg <= '0;
    else if (cfgWe) cfg <= cfgNext;
  end

  // 1 MHz enable -> 1 ms base tick
  always_ff @(posedge clk) begin
    if (!rstN) begin
      preCnt <= '0;
    end else if (refTick) begin
      if (preCnt == PRE_LAST) preCnt <= '0;
      else                    preCnt <= preCnt + 1'b1;
    end
  end
  assign baseTick = refTick && (preCnt == PRE_LAST);

  always_ff @(posedge clk) begin
    if (!rstN)         divCnt <= '0;
    else if (baseTick) divCnt <= divCnt + 1'b1;
  end

  // tickVec[k] pulses once every 2^k base ticks
  assign tickVec[0] = baseTick;
  for (genvar k = 1; k <= MAX_TICK_EXP; k++) begin : g_tick
    assign tickVec[k] = baseTick && (&divCnt[k-1:0]);
  end

  // plug code: reserved values fold onto the slowest setting
  assign plugSel = (cfg.plugCode > PLUG_CODE_MAX) ? PLUG_CODE_MAX : cfg.plugCode;
  assign plugIdx = plugSel + 3'd1;

  always_comb begin
    case (cfg.btnCode)
      2'd1:    btnTickSel = tickVec[0];
      2'd2:    btnTickSel = tickVec[1];
      2'd3:    btnTickSel = tickVec[2];
      default: btnTickSel = 1'b0;
    endcase
  end

  always_comb begin
    strobes.plugTick    = tickVec[plugIdx];
    strobes.btnTick     = btnTickSel;
    strobes.btnBypass   = (cfg.btnCode == '0);
    strobes.plugRestart = cfgWe && (cfgNext.plugCode != cfg.plugCode);
    strobes.btnRestart  = cfgWe && (cfgNext.btnCode != cfg.btnCode);
    strobes.clearAll    = !cfg.enable;
  end
endmodule

// File: rtl/hsdet_datapath.sv
module hsdet_datapath
  import hsdet_pkg::*;
#(
  parameter int SAMPLES = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         headsetRaw,
  input  logic         micRaw,
  input  ctrlStrobes_t strobes,
  output jackStatus_e  status,
  output logic         buttonPressed
);
  logic [1:0] plugSync;
  logic [1:0] micSync;
  logic       plugStable;
  logic       micStable;
  logic       btnStable;
  logic       micClear;
  logic       btnClear;

  // two-flop resynchronizers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      plugSync <= '0;
      micSync  <= '0;
    end else begin
      plugSync <= {plugSync[0], headsetRaw};
      micSync  <= {micSync[0], micRaw};
    end
  end

  assign micClear = strobes.clearAll || !plugStable;
  assign btnClear = micClear || !micStable;

  hsdet_filter #(.SAMPLES(SAMPLES)) u_plug (
    .clk(clk), .rstN(rstN),
    .clear(strobes.clearAll), .restart(strobes.plugRestart),
    .bypass(1'b0), .sampleTick(strobes.plugTick),
    .din(plugSync[1]), .stable(plugStable)
  );

  hsdet_filter #(.SAMPLES(SAMPLES)) u_mic (
    .clk(clk), .rstN(rstN),
    .clear(micClear), .restart(strobes.plugRestart),
    .bypass(1'b0), .sampleTick(strobes.plugTick),
    .din(micSync[1]), .stable(micStable)
  );

  // a press pulls the mic line low
  hsdet_filter #(.SAMPLES(SAMPLES)) u_btn (
    .clk(clk), .rstN(rstN),
    .clear(btnClear), .restart(strobes.btnRestart),
    .bypass(strobes.btnBypass), .sampleTick(strobes.btnTick),
    .din(!micSync[1]), .stable(btnStable)
  );

  always_comb begin
    if (strobes.clearAll || !plugStable) status = JACK_EMPTY;
    else if (micStable)                  status = JACK_WITH_MIC;
    else                                 status = JACK_NO_MIC;
  end

  assign buttonPressed = btnStable && !btnClear;
endmodule

// File: rtl/headset_debounce_top.sv
module headset_debounce_top
  import hsdet_pkg::*;
#(
  parameter int PRESCALE = 1000,
  parameter int SAMPLES  = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       refTick,
  input  logic       headsetRaw,
  input  logic       micRaw,
  input  logic       cfgWe,
  input  logic [5:0] cfgWdata,
  output logic [7:0] cfgRdData,
  output logic [1:0] status,
  output logic       buttonPressed
);
  detCfg_t      cfg;
  ctrlStrobes_t ctlStrobes;
  jackStatus_e  jackState;

  hsdet_ctrl #(.PRESCALE(PRESCALE)) u_ctrl (
    .clk(clk), .rstN(rstN), .refTick(refTick),
    .cfgWe(cfgWe), .cfgWdata(cfgWdata),
    .cfg(cfg), .strobes(ctlStrobes)
  );

  hsdet_datapath #(.SAMPLES(SAMPLES)) u_dp (
    .clk(clk), .rstN(rstN),
    .headsetRaw(headsetRaw), .micRaw(micRaw),
    .strobes(ctlStrobes),
    .status(jackState), .buttonPressed(buttonPressed)
  );

  assign status    = jackState;
  assign cfgRdData = {jackState, cfg};
endmodule

// File: rtl/hsdet_checker.sv
module hsdet_checker (
  input logic       clk,
  input logic       rstN,
  input logic       cfgWe,
  input logic [5:0] cfgWdata,
  input logic [7:0] cfgRdData,
  input logic [1:0] status,
  input logic       buttonPressed,
  input logic       plugTick
);
  assert_disabled_empty_R2: assert property (@(posedge clk) disable iff (!rstN)
    !cfgRdData[0] |-> (status == 2'b00 && !buttonPressed));

  assert_no_reserved_code_R3: assert property (@(posedge clk) disable iff (!rstN)
    status != 2'b10);

  // status moves only on a plug tick or a configuration write
  assert_status_on_tick_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!cfgWe && cfgRdData[0] && !plugTick) |=> $stable(status));

  assert_button_needs_mic_R9: assert property (@(posedge clk) disable iff (!rstN)
    buttonPressed |-> status == 2'b11);

  assert_readback_R11: assert property (@(posedge clk) disable iff (!rstN)
    cfgWe |=> cfgRdData[5:0] == $past(cfgWdata));
endmodule

bind headset_debounce_top hsdet_checker u_chk (
  .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgWdata(cfgWdata),
  .cfgRdData(cfgRdData), .status(status), .buttonPressed(buttonPressed),
  .plugTick(ctlStrobes.plugTick)
);

// File: tb/sim_headset_debounce_top.sv
module sim_headset_debounce_top;
  localparam int CLK_PERIOD = 10;
  localparam int PRESCALE   = 10;   // cycles per 1 ms base tick in the bench
  localparam int WATCHDOG   = 200000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       refTick = 1'b1;
  logic       headsetRaw = 1'b0;
  logic       micRaw = 1'b0;
  logic       cfgWe = 1'b0;
  logic [5:0] cfgWdata = '0;
  logic [7:0] cfgRdData;
  logic [1:0] status;
  logic       buttonPressed;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    string      tag;
    logic [1:0] st;
    logic       btn;
    bit         chkRd;
    logic [7:0] rd;
  } expItem_t;

  expItem_t expQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  headset_debounce_top #(.PRESCALE(PRESCALE), .SAMPLES(8)) u0 (
    .clk(clk), .rstN(rstN), .refTick(refTick),
    .headsetRaw(headsetRaw), .micRaw(micRaw),
    .cfgWe(cfgWe), .cfgWdata(cfgWdata),
    .cfgRdData(cfgRdData), .status(status), .buttonPressed(buttonPressed)
  );

  function automatic int tickLen(int exp2);
    return PRESCALE * (1 << exp2);
  endfunction

  task automatic waitCycles(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic writeCfg(bit en, int plug, int btn);
    @(negedge clk);
    cfgWe    = 1'b1;
    cfgWdata = {btn[1:0], plug[2:0], en};
    @(negedge clk);
    cfgWe    = 1'b0;
  endtask

  task automatic expectNow(string tag, logic [1:0] st, logic btn);
    expItem_t it;
    it.tag = tag; it.st = st; it.btn = btn; it.chkRd = 1'b0; it.rd = '0;
    expQ.push_back(it);
  endtask

  task automatic expectRd(string tag, logic [1:0] st, logic btn, logic [7:0] rd);
    expItem_t it;
    it.tag = tag; it.st = st; it.btn = btn; it.chkRd = 1'b1; it.rd = rd;
    expQ.push_back(it);
  endtask

  // monitor: compares queued expectations against the ports
  initial begin
    forever begin
      @(negedge clk);
      while (expQ.size() > 0) begin
        expItem_t it;
        it = expQ.pop_front();
        checks++;
        if (status !== it.st || buttonPressed !== it.btn ||
            (it.chkRd && cfgRdData !== it.rd)) begin
          errors++;
          $display("FAIL %s: status=%b btn=%b rd=%h expected status=%b btn=%b rd=%h",
                   it.tag, status, buttonPressed, cfgRdData, it.st, it.btn, it.rd);
        end
      end
    end
  end

  initial begin
    int t;
    waitCycles(4);
    rstN = 1'b1;
    waitCycles(2);
    expectRd("R1 reset state", 2'b00, 1'b0, 8'h00);

    // R2: inputs active, detection off
    headsetRaw = 1'b1; micRaw = 1'b1;
    waitCycles(400);
    expectNow("R2 disabled forces empty", 2'b00, 1'b0);

    // R4 / R3: plug code 0, tick 2 ms
    t = tickLen(1);
    writeCfg(1'b1, 0, 0);
    waitCycles(6 * t);
    expectNow("R4 code0 before window", 2'b00, 1'b0);
    waitCycles(3 * t + 10);
    expectNow("R3 plug without mic", 2'b01, 1'b0);
    waitCycles(9 * t + 10);
    expectRd("R3 plug with mic / R11 readback", 2'b11, 1'b0, 8'hC1);

    // R7: unfiltered button
    micRaw = 1'b0;
    waitCycles(5);
    expectNow("R7 bypass press", 2'b11, 1'b1);
    micRaw = 1'b1;
    waitCycles(5);
    expectNow("R7 bypass release", 2'b11, 1'b0);

    // R8: button code 1, tick 1 ms
    writeCfg(1'b1, 0, 1);
    t = tickLen(0);
    micRaw = 1'b0;
    waitCycles(6 * t);
    expectNow("R8 code1 before window", 2'b11, 1'b0);
    waitCycles(3 * t + 10);
    expectNow("R8 code1 press accepted", 2'b11, 1'b1);
    micRaw = 1'b1;
    waitCycles(9 * t + 10);
    expectNow("R8 code1 release accepted", 2'b11, 1'b0);

    // R8: button code 3, tick 4 ms; plug code 2 keeps mic filter slow
    writeCfg(1'b1, 2, 3);
    t = tickLen(2);
    micRaw = 1'b0;
    waitCycles(6 * t);
    expectNow("R8 code3 before window", 2'b11, 1'b0);
    waitCycles(3 * t + 10);
    expectNow("R8 code3 press accepted", 2'b11, 1'b1);
    micRaw = 1'b1;
    waitCycles(9 * t + 10);
    expectRd("R8 code3 release / R11 readback", 2'b11, 1'b0, 8'hF5);

    // R6: short plug dropout, plug tick 8 ms
    t = tickLen(3);
    headsetRaw = 1'b0;
    waitCycles(3 * t);
    headsetRaw = 1'b1;
    waitCycles(12 * t);
    expectNow("R6 short dropout rejected", 2'b11, 1'b0);

    // R9: removal clears status; mic gated while absent
    headsetRaw = 1'b0;
    waitCycles(9 * t + 10);
    expectNow("R9 removal clears status", 2'b00, 1'b0);
    writeCfg(1'b1, 0, 0);
    waitCycles(20 * tickLen(1));
    expectNow("R9 mic ignored while absent", 2'b00, 1'b0);
    t = tickLen(1);
    headsetRaw = 1'b1;
    waitCycles(9 * t + 10);
    expectNow("R9 mic restarts after plug accepted", 2'b01, 1'b0);
    micRaw = 1'b0;
    headsetRaw = 1'b0;
    waitCycles(9 * t + 10);
    expectNow("R9 empty again", 2'b00, 1'b0);
    micRaw = 1'b1;

    // R5: reserved plug code 6 acts as 64 ms tick
    writeCfg(1'b1, 6, 0);
    waitCycles(2);
    expectRd("R5 reserved code reads back", 2'b00, 1'b0, 8'h0D);
    t = tickLen(6);
    headsetRaw = 1'b1;
    waitCycles(6 * t);
    expectNow("R5 code6 before 512ms window", 2'b00, 1'b0);
    waitCycles(3 * t + 10);
    expectNow("R5 code6 accepted", 2'b01, 1'b0);

    // R10: code change mid-window restarts the count
    headsetRaw = 1'b0;
    micRaw = 1'b0;
    waitCycles(9 * t + 10);
    expectNow("R10 setup removal", 2'b00, 1'b0);
    headsetRaw = 1'b1;
    waitCycles(5 * t);
    writeCfg(1'b1, 4, 0);
    t = tickLen(5);
    waitCycles(6 * t);
    expectNow("R10 restart after code change", 2'b00, 1'b0);
    waitCycles(3 * t + 10);
    expectNow("R10 accepted after full new window", 2'b01, 1'b0);

    // R2: disabling clears at once
    writeCfg(1'b0, 4, 0);
    waitCycles(2);
    expectRd("R2 disable clears status", 2'b00, 1'b0, 8'h08);
    micRaw = 1'b0;
    waitCycles(20);
    expectNow("R2 button ignored while disabled", 2'b00, 1'b0);

    waitCycles(4);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * WATCHDOG);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule